// File: doc/BRIEF.md
# Interrupt Source Bank

This block keeps the state of a bank of interrupt sources and hands them, one at a time, to a separate presentation controller that decides whether the target processor can take them. For each source it stores a target server number and a priority, plus three flags: the line is asserted, the source needs a resend, and the source arrived while masked. Level events raise or drop a source's line. A configuration port writes and reads each source's server and priority.

Each delivery attempt sends a request carrying the global source number, the server and the priority. The request is held until the presenter answers accept or refuse. A refused or masked source is latched in its flags so that it is never lost. It is offered again when software unmasks it, when the presenter asks for a resend scan, when the presenter displaces it, or at end-of-interrupt while its line is still high. A refusal also pulses a resend-map mark, so the presenter can record that this bank owes it a resend.

Global source numbers are the bank identifier placed above the local index bits. The all-ones priority `0xFF` (with the default 8-bit priority) means masked.

Top module: `irq_src_bank`

## Requirements
- R1: After reset every source reads back server 0 and priority 0xFF (masked), no request is outstanding and no error is flagged.
- R2: A level-assert event for source i makes the block issue a request with dlv_src = {BANK_ID, i}, the stored server and the stored priority.
- R3: A deassert event only clears the asserted flag and never leads to a request.
- R4: An attempt on a source whose priority is 0xFF issues nothing and latches masked-pending. A later configuration write with a non-0xFF priority delivers it at the new priority. A write that keeps 0xFF does not deliver it. No request ever carries priority 0xFF.
- R5: When the presenter refuses a request (rsp_valid=1, rsp_accept=0), rmap_set pulses high for exactly the one cycle after the response, and the source sets its resend flag. The source is not retried by itself.
- R6: A scan_req pulse retries every source whose resend flag is set, lowest index first. An accepted attempt clears the flag, so a later scan skips that source.
- R7: An EOI for a source of this bank delivers the source again if its line is still asserted. If the line is low, nothing is sent. An EOI carrying the IPI code (IPI_CODE, default 2) is ignored.
- R8: A source reported as displaced by the presenter goes through the full delivery path, including the mask check, and is latched as masked-pending if it is masked.
- R9: Only one request is outstanding. While dlv_valid is high without a response, dlv_src and dlv_prio stay unchanged.
- R10: An event, configuration access, EOI or displacement naming a local index at or above NUM_SRC, or another bank, is dropped. It raises err for one cycle and causes no request.
- R11: A configuration read returns the stored server and priority on the cycle after cfg_rd and changes no flag.
- R12: A configuration write with a non-0xFF priority to a source whose resend flag is set delivers it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Level event strobe |
| ev_idx | input | IDX_W | Local index of the event |
| ev_level | input | 1 | 1 asserts the line, 0 deasserts it |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | IDX_W | Local index for configuration access |
| cfg_server | input | SRV_W | Server to write |
| cfg_prio | input | PRI_W | Priority to write |
| rd_valid | output | 1 | Read data valid |
| rd_server | output | SRV_W | Stored server read back |
| rd_prio | output | PRI_W | Stored priority read back |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_src | input | BID_W+IDX_W | Global source number of the EOI |
| scan_req | input | 1 | Resend-scan request |
| disp_valid | input | 1 | Displaced-source strobe from the presenter |
| disp_src | input | BID_W+IDX_W | Global number of the displaced source |
| dlv_valid | output | 1 | Delivery request outstanding |
| dlv_src | output | BID_W+IDX_W | Global source number requested |
| dlv_server | output | SRV_W | Target server of the request |
| dlv_prio | output | PRI_W | Priority of the request |
| rsp_valid | input | 1 | Presenter response strobe |
| rsp_accept | input | 1 | 1 accepted, 0 refused |
| rmap_set | output | 1 | Pulse: set this bank's bit in the resend map |
| err | output | 1 | Pulse: a request named a nonexistent source |

## Verification
The bench targets the masked-arrival path. A design that dropped masked events would stay silent after the unmask write, and one that ignored the mask would issue a 0xFF request. It refuses two sources and then scans twice. A design that walked out of index order would show the higher index first, and one that forgot to clear resend after an accept would deliver the same source again on the second scan. It sends EOI with the line high, with the line low and with the IPI code; a design that ignored the asserted flag or decoded IPI as a real source would issue a spurious request. Finally, it names indices above the populated range and another bank, where a careless decode would alias onto a real source and deliver it.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

   typedef enum logic [0:0] {
      ENG_IDLE = 1'b0,
      ENG_WAIT = 1'b1
   } eng_state_e;

   typedef struct packed {
      logic asserted;
      logic resend;
      logic mpend;
   } src_flags_t;

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
   import irq_src_pkg::*;
#(
   parameter int SRV_W = 4,
   parameter int PRI_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_set,
   input  logic             ev_clr,
   input  logic             wr_en,
   input  logic [SRV_W-1:0] wr_server,
   input  logic [PRI_W-1:0] wr_prio,
   input  logic             att_start,
   input  logic             rej,
   input  logic             trig_scan,
   input  logic             trig_eoi,
   input  logic             trig_disp,
   output logic [SRV_W-1:0] server_q,
   output logic [PRI_W-1:0] prio_q,
   output logic             try_q
);

   localparam logic [PRI_W-1:0] MASK = {PRI_W{1'b1}};

   src_flags_t fl_q, fl_d;
   logic       att_masked;
   logic       wr_fire;
   logic       try_set;

   assign att_masked = att_start && (prio_q == MASK);
   // an unmask write fires on latched state, or on a masked attempt in the same cycle
   assign wr_fire    = wr_en && (wr_prio != MASK) &&
                       (fl_q.mpend || fl_q.resend || att_masked);
   assign try_set    = ev_set || wr_fire || trig_disp ||
                       (trig_scan && fl_q.resend) ||
                       (trig_eoi && fl_q.asserted);

   always_comb begin
      fl_d = fl_q;
      if (ev_set)      fl_d.asserted = 1'b1;
      else if (ev_clr) fl_d.asserted = 1'b0;
      if (rej)            fl_d.resend = 1'b1;
      else if (att_start) fl_d.resend = 1'b0;
      if (wr_fire)         fl_d.mpend = 1'b0;
      else if (att_masked) fl_d.mpend = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_q     <= '0;
         try_q    <= 1'b0;
         server_q <= '0;
         prio_q   <= MASK;
      end else begin
         fl_q <= fl_d;
         if (try_set)        try_q <= 1'b1;
         else if (att_start) try_q <= 1'b0;
         if (wr_en) begin
            server_q <= wr_server;
            prio_q   <= wr_prio;
         end
      end
   end

endmodule

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
   parameter int N = 6,
   parameter int W = 3
) (
   input  logic [N-1:0] req,
   output logic         valid,
   output logic [W-1:0] idx
);

   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            valid = 1'b1;
            idx   = W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_src_engine.sv
module irq_src_engine
   import irq_src_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int SRV_W = 4,
   parameter int PRI_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pick_valid,
   input  logic [IDX_W-1:0] pick_idx,
   input  logic [SRV_W-1:0] sel_server,
   input  logic [PRI_W-1:0] sel_prio,
   input  logic             rsp_valid,
   input  logic             rsp_accept,
   output logic             att_go,
   output logic             rej_go,
   output logic [IDX_W-1:0] cur_idx,
   output logic             busy,
   output logic [SRV_W-1:0] cur_server,
   output logic [PRI_W-1:0] cur_prio,
   output logic             rmap_q
);

   localparam logic [PRI_W-1:0] MASK = {PRI_W{1'b1}};

   eng_state_e st_q;

   assign att_go = (st_q == ENG_IDLE) && pick_valid;
   assign rej_go = (st_q == ENG_WAIT) && rsp_valid && !rsp_accept;
   assign busy   = (st_q == ENG_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ENG_IDLE;
         cur_idx    <= '0;
         cur_server <= '0;
         cur_prio   <= MASK;
         rmap_q     <= 1'b0;
      end else begin
         rmap_q <= 1'b0;
         case (st_q)
            ENG_IDLE: begin
               if (pick_valid) begin
                  cur_idx <= pick_idx;
                  if (sel_prio != MASK) begin
                     st_q       <= ENG_WAIT;
                     cur_server <= sel_server;
                     cur_prio   <= sel_prio;
                  end
               end
            end
            ENG_WAIT: begin
               if (rsp_valid) begin
                  st_q   <= ENG_IDLE;
                  rmap_q <= !rsp_accept;
               end
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import irq_src_pkg::*;
#(
   parameter int IDX_W    = 3,
   parameter int NUM_SRC  = 6,
   parameter int BID_W    = 4,
   parameter int BANK_ID  = 5,
   parameter int SRV_W    = 4,
   parameter int PRI_W    = 8,
   parameter int IPI_CODE = 2,
   parameter int RD_LAT   = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ev_valid,
   input  logic [IDX_W-1:0]       ev_idx,
   input  logic                   ev_level,
   input  logic                   cfg_wr,
   input  logic                   cfg_rd,
   input  logic [IDX_W-1:0]       cfg_idx,
   input  logic [SRV_W-1:0]       cfg_server,
   input  logic [PRI_W-1:0]       cfg_prio,
   output logic                   rd_valid,
   output logic [SRV_W-1:0]       rd_server,
   output logic [PRI_W-1:0]       rd_prio,
   input  logic                   eoi_valid,
   input  logic [BID_W+IDX_W-1:0] eoi_src,
   input  logic                   scan_req,
   input  logic                   disp_valid,
   input  logic [BID_W+IDX_W-1:0] disp_src,
   output logic                   dlv_valid,
   output logic [BID_W+IDX_W-1:0] dlv_src,
   output logic [SRV_W-1:0]       dlv_server,
   output logic [PRI_W-1:0]       dlv_prio,
   input  logic                   rsp_valid,
   input  logic                   rsp_accept,
   output logic                   rmap_set,
   output logic                   err
);

   localparam int               SRC_W   = BID_W + IDX_W;
   localparam logic [IDX_W:0]   NSRC    = (IDX_W + 1)'(NUM_SRC);
   localparam logic [BID_W-1:0] BANK    = BID_W'(BANK_ID);
   localparam logic [SRC_W-1:0] IPI_SRC = SRC_W'(IPI_CODE);

   if (NUM_SRC < 1 || NUM_SRC > (1 << IDX_W)) begin : g_bad_num
      $error("irq_src_bank: NUM_SRC must lie in 1 .. 2**IDX_W");
   end
   if (BANK_ID < 0 || BANK_ID >= (1 << BID_W)) begin : g_bad_bank
      $error("irq_src_bank: BANK_ID does not fit in BID_W bits");
   end
   if (PRI_W < 2 || SRV_W < 1) begin : g_bad_w
      $error("irq_src_bank: PRI_W must be >= 2 and SRV_W >= 1");
   end
   if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_lat
      $error("irq_src_bank: RD_LAT must be 0 or 1");
   end

   // ---------------- request decode ----------------
   logic             ev_ok, cfg_ok;
   logic             eoi_ipi, eoi_hit, eoi_ok, disp_hit, disp_ok;
   logic [IDX_W-1:0] eoi_idx, disp_idx;
   logic             bad_any;

   assign ev_ok    = ({1'b0, ev_idx} < NSRC);
   assign cfg_ok   = ({1'b0, cfg_idx} < NSRC);
   assign eoi_idx  = eoi_src[IDX_W-1:0];
   assign disp_idx = disp_src[IDX_W-1:0];
   assign eoi_ipi  = (eoi_src == IPI_SRC);
   assign eoi_hit  = (eoi_src[SRC_W-1:IDX_W] == BANK) && ({1'b0, eoi_idx} < NSRC);
   assign disp_hit = (disp_src[SRC_W-1:IDX_W] == BANK) && ({1'b0, disp_idx} < NSRC);
   assign eoi_ok   = eoi_valid && !eoi_ipi && eoi_hit;
   assign disp_ok  = disp_valid && disp_hit;
   assign bad_any  = (ev_valid && !ev_ok) ||
                     ((cfg_wr || cfg_rd) && !cfg_ok) ||
                     (eoi_valid && !eoi_ipi && !eoi_hit) ||
                     (disp_valid && !disp_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) err <= 1'b0;
      else        err <= bad_any;
   end

   // ---------------- per-source state ----------------
   logic [SRV_W-1:0] srv_a [NUM_SRC];
   logic [PRI_W-1:0] pri_a [NUM_SRC];
   logic [NUM_SRC-1:0] try_vec;

   logic             pick_valid;
   logic [IDX_W-1:0] pick_idx;
   logic             att_go, rej_go, busy;
   logic [IDX_W-1:0] cur_idx;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic here_ev, here_cfg, here_eoi, here_disp;
      assign here_ev   = ev_valid && ev_ok && (ev_idx == IDX_W'(i));
      assign here_cfg  = cfg_wr && cfg_ok && (cfg_idx == IDX_W'(i));
      assign here_eoi  = eoi_ok && (eoi_idx == IDX_W'(i));
      assign here_disp = disp_ok && (disp_idx == IDX_W'(i));

      irq_src_slot #(
         .SRV_W (SRV_W),
         .PRI_W (PRI_W)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .ev_set    (here_ev && ev_level),
         .ev_clr    (here_ev && !ev_level),
         .wr_en     (here_cfg),
         .wr_server (cfg_server),
         .wr_prio   (cfg_prio),
         .att_start (att_go && (pick_idx == IDX_W'(i))),
         .rej       (rej_go && (cur_idx == IDX_W'(i))),
         .trig_scan (scan_req),
         .trig_eoi  (here_eoi),
         .trig_disp (here_disp),
         .server_q  (srv_a[i]),
         .prio_q    (pri_a[i]),
         .try_q     (try_vec[i])
      );
   end

   // ---------------- selection and muxing ----------------
   irq_src_pick #(
      .N (NUM_SRC),
      .W (IDX_W)
   ) u_pick (
      .req   (try_vec),
      .valid (pick_valid),
      .idx   (pick_idx)
   );

   logic [SRV_W-1:0] sel_server, rdm_server;
   logic [PRI_W-1:0] sel_prio, rdm_prio;

   always_comb begin
      sel_server = '0;
      sel_prio   = {PRI_W{1'b1}};
      rdm_server = '0;
      rdm_prio   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pick_idx == IDX_W'(i)) begin
            sel_server = srv_a[i];
            sel_prio   = pri_a[i];
         end
         if (cfg_idx == IDX_W'(i)) begin
            rdm_server = srv_a[i];
            rdm_prio   = pri_a[i];
         end
      end
   end

   irq_src_engine #(
      .IDX_W (IDX_W),
      .SRV_W (SRV_W),
      .PRI_W (PRI_W)
   ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .pick_valid (pick_valid),
      .pick_idx   (pick_idx),
      .sel_server (sel_server),
      .sel_prio   (sel_prio),
      .rsp_valid  (rsp_valid),
      .rsp_accept (rsp_accept),
      .att_go     (att_go),
      .rej_go     (rej_go),
      .cur_idx    (cur_idx),
      .busy       (busy),
      .cur_server (dlv_server),
      .cur_prio   (dlv_prio),
      .rmap_q     (rmap_set)
   );

   assign dlv_valid = busy;
   assign dlv_src   = {BANK, cur_idx};

   // ---------------- configuration read ----------------
   if (RD_LAT == 1) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_server <= '0;
            rd_prio   <= '0;
         end else begin
            rd_valid  <= cfg_rd;
            rd_server <= cfg_ok ? rdm_server : '0;
            rd_prio   <= cfg_ok ? rdm_prio : '0;
         end
      end
   end else begin : g_rd_comb
      assign rd_valid  = cfg_rd;
      assign rd_server = cfg_ok ? rdm_server : '0;
      assign rd_prio   = cfg_ok ? rdm_prio : '0;
   end

endmodule

// File: rtl/irq_src_bank_chk.sv
module irq_src_bank_chk #(
   parameter int IDX_W   = 3,
   parameter int NUM_SRC = 6,
   parameter int BID_W   = 4,
   parameter int BANK_ID = 5,
   parameter int PRI_W   = 8,
   parameter int RD_LAT  = 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   dlv_valid,
   input logic [BID_W+IDX_W-1:0] dlv_src,
   input logic [PRI_W-1:0]       dlv_prio,
   input logic                   rsp_valid,
   input logic                   rsp_accept,
   input logic                   rmap_set,
   input logic                   cfg_rd,
   input logic                   rd_valid
);

   localparam logic [PRI_W-1:0] MASK = {PRI_W{1'b1}};
   localparam logic [BID_W-1:0] BANK = BID_W'(BANK_ID);
   localparam logic [IDX_W:0]   NSRC = (IDX_W + 1)'(NUM_SRC);

   // R9: a waiting request does not change
   a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && !rsp_valid) |=> (dlv_valid && $stable(dlv_src) && $stable(dlv_prio)));

   // R4: never a request at the masked priority
   a_r4_no_masked_request: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> (dlv_prio != MASK));

   // R5: the resend mark follows only a refusal of an outstanding request
   a_r5_mark_after_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      rmap_set |-> $past(dlv_valid && rsp_valid && !rsp_accept));

   // R5: the mark lasts one cycle
   a_r5_mark_single: assert property (@(posedge clk) disable iff (!rst_n)
      rmap_set |=> !rmap_set);

   // R10: requests name only populated sources of this bank
   a_r10_request_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> ((dlv_src[BID_W+IDX_W-1:IDX_W] == BANK) &&
                     ({1'b0, dlv_src[IDX_W-1:0]} < NSRC)));

   if (RD_LAT == 1) begin : g_rd_chk
      // R11: read data follows a read strobe by one cycle
      a_r11_read_timing: assert property (@(posedge clk) disable iff (!rst_n)
         rd_valid |-> $past(cfg_rd));
   end

endmodule

bind irq_src_bank irq_src_bank_chk #(
   .IDX_W   (IDX_W),
   .NUM_SRC (NUM_SRC),
   .BID_W   (BID_W),
   .BANK_ID (BANK_ID),
   .PRI_W   (PRI_W),
   .RD_LAT  (RD_LAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dlv_valid  (dlv_valid),
   .dlv_src    (dlv_src),
   .dlv_prio   (dlv_prio),
   .rsp_valid  (rsp_valid),
   .rsp_accept (rsp_accept),
   .rmap_set   (rmap_set),
   .cfg_rd     (cfg_rd),
   .rd_valid   (rd_valid)
);

// File: tb/irq_src_bank_tb_top.sv
`timescale 1ns/1ps
module irq_src_bank_tb_top;

   localparam int IDX_W = 3, NUM_SRC = 6, BID_W = 4, BANK_ID = 5;
   localparam int SRV_W = 4, PRI_W = 8, SRC_W = BID_W + IDX_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_valid = 0, ev_level = 0, cfg_wr = 0, cfg_rd = 0;
   logic [IDX_W-1:0] ev_idx = '0, cfg_idx = '0;
   logic [SRV_W-1:0] cfg_server = '0;
   logic [PRI_W-1:0] cfg_prio = '0;
   logic eoi_valid = 0, scan_req = 0, disp_valid = 0, rsp_valid = 0, rsp_accept = 0;
   logic [SRC_W-1:0] eoi_src = '0, disp_src = '0;
   logic rd_valid, dlv_valid, rmap_set, err;
   logic [SRV_W-1:0] rd_server, dlv_server;
   logic [PRI_W-1:0] rd_prio, dlv_prio;
   logic [SRC_W-1:0] dlv_src;

   int nchk = 0, nfail = 0, err_cnt = 0, rmap_cnt = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   irq_src_bank dut_i (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_level(ev_level),
      .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
      .cfg_server(cfg_server), .cfg_prio(cfg_prio),
      .rd_valid(rd_valid), .rd_server(rd_server), .rd_prio(rd_prio),
      .eoi_valid(eoi_valid), .eoi_src(eoi_src), .scan_req(scan_req),
      .disp_valid(disp_valid), .disp_src(disp_src),
      .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_server(dlv_server),
      .dlv_prio(dlv_prio), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
      .rmap_set(rmap_set), .err(err)
   );

   always @(negedge clk) begin
      if (rst_n && err) err_cnt++;
      if (rst_n && rmap_set) rmap_cnt++;
   end

   function automatic int gsrc(int idx);
      return (BANK_ID << IDX_W) | idx;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic ev(int idx, bit lvl);
      ev_valid = 1; ev_idx = IDX_W'(idx); ev_level = lvl;
      @(negedge clk);
      ev_valid = 0;
   endtask

   task automatic cfg_write(int idx, int srv, int pri);
      cfg_wr = 1; cfg_idx = IDX_W'(idx); cfg_server = SRV_W'(srv); cfg_prio = PRI_W'(pri);
      @(negedge clk);
      cfg_wr = 0;
   endtask

   task automatic cfg_read(int idx, output int srv, output int pri);
      cfg_rd = 1; cfg_idx = IDX_W'(idx);
      @(negedge clk);
      cfg_rd = 0;
      srv = int'(rd_server); pri = int'(rd_prio);
   endtask

   task automatic eoi(int src);
      eoi_valid = 1; eoi_src = SRC_W'(src);
      @(negedge clk);
      eoi_valid = 0;
   endtask

   task automatic disp(int src);
      disp_valid = 1; disp_src = SRC_W'(src);
      @(negedge clk);
      disp_valid = 0;
   endtask

   task automatic scan();
      scan_req = 1;
      @(negedge clk);
      scan_req = 0;
   endtask

   task automatic respond(bit acc);
      rsp_valid = 1; rsp_accept = acc;
      @(negedge clk);
      rsp_valid = 0;
   endtask

   // waits for a request, checks it and answers it
   task automatic expect_dlv(string req, int idx, int srv, int pri, bit acc);
      bit got = 0;
      for (int k = 0; k < 8 && !got; k++) begin
         if (dlv_valid) got = 1;
         else @(negedge clk);
      end
      chk(req, "request seen", int'(got), 1);
      if (got) begin
         chk(req, "dlv_src", int'(dlv_src), gsrc(idx));
         chk(req, "dlv_prio", int'(dlv_prio), pri);
         chk(req, "dlv_server", int'(dlv_server), srv);
         respond(acc);
      end
   endtask

   task automatic expect_quiet(string req, int n);
      int seen = 0;
      for (int k = 0; k < n; k++) begin
         if (dlv_valid) seen++;
         @(negedge clk);
      end
      chk(req, "cycles with a request", seen, 0);
   endtask

   task automatic t_reset();
      int s, p;
      chk("R1", "dlv_valid after reset", int'(dlv_valid), 0);
      chk("R1", "err after reset", int'(err), 0);
      cfg_read(3, s, p);
      chk("R1", "reset server", s, 0);
      chk("R1", "reset priority", p, 255);
   endtask

   task automatic t_masked();
      int s, p;
      ev(0, 1);
      expect_quiet("R4", 5);
      cfg_write(0, 3, 255);
      expect_quiet("R4", 5);
      cfg_read(0, s, p);                 // R11: read has no side effect
      expect_quiet("R11", 4);
      cfg_write(0, 3, 16);
      expect_dlv("R4", 0, 3, 16, 1);
      cfg_read(0, s, p);
      chk("R11", "read server", s, 3);
      chk("R11", "read priority", p, 16);
      ev(0, 0);
   endtask

   task automatic t_assert_hold();
      cfg_write(1, 1, 32);
      expect_quiet("R2", 4);
      ev(1, 1);
      repeat (4) @(negedge clk);         // leave it waiting
      chk("R9", "request held", int'(dlv_valid), 1);
      chk("R9", "held src", int'(dlv_src), gsrc(1));
      expect_dlv("R2", 1, 1, 32, 1);
   endtask

   task automatic t_eoi();
      eoi(gsrc(1));                       // line still high
      expect_dlv("R7", 1, 1, 32, 1);
      eoi(2);                             // IPI code
      expect_quiet("R7", 5);
      ev(1, 0);
      expect_quiet("R3", 5);
      eoi(gsrc(1));                       // line low
      expect_quiet("R7", 5);
   endtask

   task automatic t_refuse_scan();
      int m0;
      cfg_write(2, 2, 48);
      cfg_write(3, 4, 64);
      m0 = rmap_cnt;
      ev(3, 1);
      expect_dlv("R5", 3, 4, 64, 0);
      @(negedge clk);
      chk("R5", "resend mark pulses", rmap_cnt - m0, 1);
      expect_quiet("R5", 5);
      ev(2, 1);
      expect_dlv("R5", 2, 2, 48, 0);
      scan();
      expect_dlv("R6", 2, 2, 48, 1);      // lowest index first
      expect_dlv("R6", 3, 4, 64, 0);
      scan();
      expect_dlv("R6", 3, 4, 64, 1);      // index 2 no longer owed
      expect_quiet("R6", 5);
      scan();
      expect_quiet("R6", 5);
   endtask

   task automatic t_resend_cfg();
      cfg_write(4, 6, 80);
      ev(4, 1);
      expect_dlv("R12", 4, 6, 80, 0);
      cfg_write(4, 7, 85);
      expect_dlv("R12", 4, 7, 85, 1);
   endtask

   task automatic t_disp();
      disp(gsrc(4));
      expect_dlv("R8", 4, 7, 85, 1);
      cfg_write(4, 7, 255);
      disp(gsrc(4));
      expect_quiet("R8", 5);
      cfg_write(4, 7, 96);
      expect_dlv("R8", 4, 7, 96, 1);
   endtask

   task automatic t_errors();
      int e0 = err_cnt;
      ev(6, 1);
      @(negedge clk);
      chk("R10", "err for index 6", err_cnt - e0, 1);
      expect_quiet("R10", 4);
      e0 = err_cnt;
      eoi((3 << IDX_W) | 1);              // another bank
      @(negedge clk);
      chk("R10", "err for foreign EOI", err_cnt - e0, 1);
      expect_quiet("R10", 4);
      e0 = err_cnt;
      cfg_write(7, 1, 8);
      @(negedge clk);
      chk("R10", "err for index 7 write", err_cnt - e0, 1);
      expect_quiet("R10", 4);
   endtask

   task automatic t_read_noside();
      int s, p;
      ev(5, 1);                           // masked: latched
      for (int k = 0; k < 3; k++) cfg_read(5, s, p);
      expect_quiet("R11", 4);
      chk("R11", "masked priority read", p, 255);
      cfg_write(5, 9, 112);
      expect_dlv("R11", 5, 9, 112, 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_masked();
      t_assert_hold();
      t_eoi();
      t_refuse_scan();
      t_resend_cfg();
      t_disp();
      t_errors();
      t_read_noside();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

endmodule